// File: doc/BRIEF.md
# Timed Fuse and Signature Readback

This block sits next to the program-memory read path of a small CPU. A load-program-memory (LPM) strobe normally returns the flash byte presented on `flash_data_i`. Software can instead arm a short redirect window. It does this by writing a control word with an enable bit and one of two mode bits. One mode sends LPM reads to the fuse and lock bytes. The other sends them to the device signature row, which holds the ID bytes, the oscillator calibration byte and the temperature-sensor trims.

The window lasts three CPU cycles after the control write. It closes at the first LPM that uses it, or when the three cycles pass with no LPM. After it closes, LPM returns ordinary flash data again. The enable bit stays visible in the control readback and on `busy_o`. Software polls it before arming a new window.

Fuse and lock values arrive as "programmed" flags. A programmed bit reads back as 0 and an unprogrammed bit reads back as 1. The read byte is registered and appears one cycle after the strobe, together with a valid pulse.

Top module: `fuse_sig_readback`

## Requirements
- R1: Arming needs three things in one cycle: `ctl_we_i` high, `busy_o` low, and control bit 0 (enable) set together with bit 3 (fuse mode) or bit 5 (signature mode). On the next cycle `ctl_rdata_o` shows the enable bit and the stored mode bit, and all its other bits read 0. A write without enable, or without a mode bit, arms nothing.
- R2: Once armed, the window stays open for exactly three cycles. If no LPM occurs in that time, the enable and mode bits clear by themselves and `busy_o` falls.
- R3: An LPM taken while the window is open returns the redirected byte. On the next cycle the enable and mode bits are clear.
- R4: In fuse mode, pointer 0x0000 selects the fuse low byte, 0x0001 the lock byte, 0x0002 the extended fuse byte and 0x0003 the fuse high byte.
- R5: Each fuse and lock byte reads as the bitwise inverse of its programmed-flag input (programmed reads 0).
- R6: In signature mode, pointer 0x0000 selects signature byte 1, 0x0001 the oscillator calibration byte, 0x0002 signature byte 2, 0x0004 signature byte 3, 0x0005 the temperature offset and 0x0007 the temperature gain.
- R7: In either mode, every other pointer value returns 0xFF.
- R8: When a control write sets both mode bits, signature mode is stored and bit 3 reads 0.
- R9: An LPM taken while no window is open returns `flash_data_i` from the strobe cycle.
- R10: A control write while `busy_o` is high has no effect. The window neither restarts nor changes mode.
- R11: `rd_valid_o` is high exactly in the cycle after each `lpm_i` cycle. `rd_data_o` carries the selected byte in that cycle.
- R12: While reset is asserted, `busy_o`, `rd_valid_o`, `rd_data_o` and `ctl_rdata_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control write data (bit0 enable, bit3 fuse mode, bit5 signature mode) |
| ctl_rdata_o | output | 8 | Control register readback |
| busy_o | output | 1 | Window open (enable bit) |
| lpm_i | input | 1 | LPM read strobe |
| lpm_addr_i | input | 16 | Pointer address |
| flash_data_i | input | 8 | Flash byte at the pointer in the strobe cycle |
| fuse_lo_pgm_i | input | 8 | Fuse low programmed flags |
| fuse_hi_pgm_i | input | 8 | Fuse high programmed flags |
| fuse_ext_pgm_i | input | 8 | Extended fuse programmed flags |
| lock_pgm_i | input | 8 | Lock programmed flags |
| sig_b1_i | input | 8 | Device signature byte 1 |
| sig_b2_i | input | 8 | Device signature byte 2 |
| sig_b3_i | input | 8 | Device signature byte 3 |
| osc_cal_i | input | 8 | Oscillator calibration byte |
| ts_offset_i | input | 8 | Temperature sensor offset |
| ts_gain_i | input | 8 | Temperature sensor gain |
| rd_data_o | output | 8 | Registered read byte |
| rd_valid_o | output | 1 | Read byte valid |

## Verification
The properties assume that every input is driven to known values from reset onward. They also assume `flash_data_i` is valid in the same cycle as its strobe, because the pass-through property compares the returned byte with the flash byte from that cycle. The stimulus changes every input only on the falling edge. Each cycle draws a fresh flash byte. Pointers are drawn mostly from the small decoded range, with occasional wide values. Control writes come from unconstrained random bytes, so every combination of enable and mode bits occurs, including writes made while a window is already open.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int unsigned CTL_EN_BIT   = 0;
  localparam int unsigned CTL_FUSE_BIT = 3;
  localparam int unsigned CTL_SIG_BIT  = 5;
  localparam logic [7:0]  RSVD_BYTE    = 8'hFF;

  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_FUSE = 2'd1,
    MODE_SIG  = 2'd2
  } mode_e;
endpackage

// File: rtl/fsr_window_ctrl.sv
module fsr_window_ctrl
  import fsr_pkg::*;
#(
  parameter int unsigned WIN_CYCLES = 3,
  parameter int unsigned CTL_W      = 8,
  parameter int unsigned CNT_W      = $clog2(WIN_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  input  logic             lpm_i,
  output mode_e            mode_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             open_o
);
  logic [CNT_W-1:0] cnt_q;
  mode_e            mode_q;
  logic             arm;
  logic             want_sig;
  logic             want_fuse;

  assign want_sig  = wdata_i[CTL_SIG_BIT];
  assign want_fuse = wdata_i[CTL_FUSE_BIT];
  assign arm       = we_i && wdata_i[CTL_EN_BIT] && (want_sig || want_fuse);
  assign open_o    = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= MODE_NONE;
    end else if (open_o) begin
      // writes while open are dropped
      if (lpm_i) begin
        cnt_q  <= '0;
        mode_q <= MODE_NONE;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) mode_q <= MODE_NONE;
      end
    end else if (arm) begin
      cnt_q  <= CNT_W'(WIN_CYCLES);
      mode_q <= want_sig ? MODE_SIG : MODE_FUSE;
    end
  end

  assign mode_o = mode_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/fsr_fuse_sel.sv
module fsr_fuse_sel
  import fsr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] lo_pgm_i,
  input  logic [DATA_W-1:0] lock_pgm_i,
  input  logic [DATA_W-1:0] ext_pgm_i,
  input  logic [DATA_W-1:0] hi_pgm_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned NSLOT = 4;
  logic [DATA_W-1:0] pgm_slot [NSLOT];
  logic [DATA_W-1:0] rd_slot  [NSLOT];

  assign pgm_slot[0] = lo_pgm_i;
  assign pgm_slot[1] = lock_pgm_i;
  assign pgm_slot[2] = ext_pgm_i;
  assign pgm_slot[3] = hi_pgm_i;

  // programmed cells read as zero
  for (genvar g = 0; g < NSLOT; g++) begin : g_inv
    assign rd_slot[g] = ~pgm_slot[g];
  end

  always_comb begin
    data_o = DATA_W'(RSVD_BYTE);
    for (int i = 0; i < NSLOT; i++) begin
      if (addr_i == ADDR_W'(i)) data_o = rd_slot[i];
    end
  end
endmodule

// File: rtl/fsr_sig_sel.sv
module fsr_sig_sel
  import fsr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] sig_b1_i,
  input  logic [DATA_W-1:0] sig_b2_i,
  input  logic [DATA_W-1:0] sig_b3_i,
  input  logic [DATA_W-1:0] osc_cal_i,
  input  logic [DATA_W-1:0] ts_offset_i,
  input  logic [DATA_W-1:0] ts_gain_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    data_o = DATA_W'(RSVD_BYTE);
    if (addr_i[ADDR_W-1:3] == '0) begin
      unique case (addr_i[2:0])
        3'd0:    data_o = sig_b1_i;
        3'd1:    data_o = osc_cal_i;
        3'd2:    data_o = sig_b2_i;
        3'd4:    data_o = sig_b3_i;
        3'd5:    data_o = ts_offset_i;
        3'd7:    data_o = ts_gain_i;
        default: data_o = DATA_W'(RSVD_BYTE);
      endcase
    end
  end
endmodule

// File: rtl/fuse_sig_readback.sv
module fuse_sig_readback
  import fsr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned WIN_CYCLES = 3,
  localparam int unsigned CNT_W     = $clog2(WIN_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic [7:0]        ctl_wdata_i,
  output logic [7:0]        ctl_rdata_o,
  output logic              busy_o,
  input  logic              lpm_i,
  input  logic [ADDR_W-1:0] lpm_addr_i,
  input  logic [DATA_W-1:0] flash_data_i,
  input  logic [DATA_W-1:0] fuse_lo_pgm_i,
  input  logic [DATA_W-1:0] fuse_hi_pgm_i,
  input  logic [DATA_W-1:0] fuse_ext_pgm_i,
  input  logic [DATA_W-1:0] lock_pgm_i,
  input  logic [DATA_W-1:0] sig_b1_i,
  input  logic [DATA_W-1:0] sig_b2_i,
  input  logic [DATA_W-1:0] sig_b3_i,
  input  logic [DATA_W-1:0] osc_cal_i,
  input  logic [DATA_W-1:0] ts_offset_i,
  input  logic [DATA_W-1:0] ts_gain_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  mode_e             win_mode;
  logic [CNT_W-1:0]  win_cnt;
  logic              win_open;
  logic [DATA_W-1:0] fuse_byte;
  logic [DATA_W-1:0] sig_byte;
  logic [DATA_W-1:0] sel_byte;
  logic [DATA_W-1:0] rd_data_q;
  logic              rd_valid_q;

  fsr_window_ctrl #(
    .WIN_CYCLES(WIN_CYCLES),
    .CTL_W     (8),
    .CNT_W     (CNT_W)
  ) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ctl_we_i),
    .wdata_i(ctl_wdata_i),
    .lpm_i  (lpm_i),
    .mode_o (win_mode),
    .cnt_o  (win_cnt),
    .open_o (win_open)
  );

  fsr_fuse_sel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fuse (
    .addr_i    (lpm_addr_i),
    .lo_pgm_i  (fuse_lo_pgm_i),
    .lock_pgm_i(lock_pgm_i),
    .ext_pgm_i (fuse_ext_pgm_i),
    .hi_pgm_i  (fuse_hi_pgm_i),
    .data_o    (fuse_byte)
  );

  fsr_sig_sel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sig (
    .addr_i     (lpm_addr_i),
    .sig_b1_i   (sig_b1_i),
    .sig_b2_i   (sig_b2_i),
    .sig_b3_i   (sig_b3_i),
    .osc_cal_i  (osc_cal_i),
    .ts_offset_i(ts_offset_i),
    .ts_gain_i  (ts_gain_i),
    .data_o     (sig_byte)
  );

  always_comb begin
    sel_byte = flash_data_i;
    if (win_open) begin
      unique case (win_mode)
        MODE_FUSE: sel_byte = fuse_byte;
        MODE_SIG:  sel_byte = sig_byte;
        default:   sel_byte = flash_data_i;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= lpm_i;
      if (lpm_i) rd_data_q <= sel_byte;
    end
  end

  always_comb begin
    ctl_rdata_o               = '0;
    ctl_rdata_o[CTL_EN_BIT]   = win_open;
    ctl_rdata_o[CTL_FUSE_BIT] = win_open && (win_mode == MODE_FUSE);
    ctl_rdata_o[CTL_SIG_BIT]  = win_open && (win_mode == MODE_SIG);
  end

  assign busy_o     = win_open;
  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned WIN_CYCLES = 3,
  parameter int unsigned CNT_W      = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctl_we_i,
  input logic [7:0]        ctl_wdata_i,
  input logic [7:0]        ctl_rdata_o,
  input logic              busy_o,
  input logic              lpm_i,
  input logic [DATA_W-1:0] flash_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rd_valid_o,
  input logic [CNT_W-1:0]  cnt_i
);
  AST_CNT_MATCH_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != '0) == busy_o); // R2

  AST_WINDOW_EXPIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == CNT_W'(1)) && !lpm_i |=> !busy_o); // R2

  AST_ARM_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && ctl_we_i && ctl_wdata_i[0] && (ctl_wdata_i[3] || ctl_wdata_i[5])
    |=> (cnt_i == CNT_W'(WIN_CYCLES)) && busy_o); // R1

  AST_LPM_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && lpm_i |=> !busy_o && (ctl_rdata_o == 8'h00)); // R3

  AST_MODE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctl_rdata_o[3], ctl_rdata_o[5]})); // R8

  AST_PASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lpm_i && !busy_o |=> rd_data_o == $past(flash_data_i)); // R9

  AST_BUSY_WRITE_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && ctl_we_i |=> cnt_i != CNT_W'(WIN_CYCLES)); // R10

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lpm_i |=> rd_valid_o); // R11

  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lpm_i |=> !rd_valid_o); // R11
endmodule

bind fuse_sig_readback fsr_checker #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .WIN_CYCLES(WIN_CYCLES),
  .CNT_W     (CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctl_we_i    (ctl_we_i),
  .ctl_wdata_i (ctl_wdata_i),
  .ctl_rdata_o (ctl_rdata_o),
  .busy_o      (busy_o),
  .lpm_i       (lpm_i),
  .flash_data_i(flash_data_i),
  .rd_data_o   (rd_data_o),
  .rd_valid_o  (rd_valid_o),
  .cnt_i       (win_cnt)
);

// File: tb/sim_fuse_sig_readback.sv
module sim_fuse_sig_readback;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctl_we_i = 1'b0;
  logic [7:0]  ctl_wdata_i = '0;
  logic [7:0]  ctl_rdata_o;
  logic        busy_o;
  logic        lpm_i = 1'b0;
  logic [15:0] lpm_addr_i = '0;
  logic [7:0]  flash_data_i = '0;
  logic [7:0]  fuse_lo_pgm_i = '0, fuse_hi_pgm_i = '0, fuse_ext_pgm_i = '0, lock_pgm_i = '0;
  logic [7:0]  sig_b1_i = '0, sig_b2_i = '0, sig_b3_i = '0;
  logic [7:0]  osc_cal_i = '0, ts_offset_i = '0, ts_gain_i = '0;
  logic [7:0]  rd_data_o;
  logic        rd_valid_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  int m_cnt = 0;
  bit m_sig = 0;

  always #4 clk_i = ~clk_i;

  fuse_sig_readback u0 (.*);

  function automatic logic [7:0] exp_fuse(input logic [15:0] a);
    case (a)
      16'd0:   return ~fuse_lo_pgm_i;
      16'd1:   return ~lock_pgm_i;
      16'd2:   return ~fuse_ext_pgm_i;
      16'd3:   return ~fuse_hi_pgm_i;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] exp_sig(input logic [15:0] a);
    case (a)
      16'd0:   return sig_b1_i;
      16'd1:   return osc_cal_i;
      16'd2:   return sig_b2_i;
      16'd4:   return sig_b3_i;
      16'd5:   return ts_offset_i;
      16'd7:   return ts_gain_i;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic randomize_static();
    fuse_lo_pgm_i = 8'($urandom); fuse_hi_pgm_i = 8'($urandom);
    fuse_ext_pgm_i = 8'($urandom); lock_pgm_i = 8'($urandom);
    sig_b1_i = 8'($urandom); sig_b2_i = 8'($urandom); sig_b3_i = 8'($urandom);
    osc_cal_i = 8'($urandom); ts_offset_i = 8'($urandom); ts_gain_i = 8'($urandom);
  endtask

  // one cycle: drive at negedge, check after the next posedge
  task automatic step(input bit we, input logic [7:0] wd, input bit lpm,
                      input logic [15:0] addr, input string req);
    logic [7:0] flash, exp_d, exp_ctl;
    flash = 8'($urandom);
    ctl_we_i = we; ctl_wdata_i = wd; lpm_i = lpm; lpm_addr_i = addr; flash_data_i = flash;
    if (m_cnt != 0 && lpm) exp_d = m_sig ? exp_sig(addr) : exp_fuse(addr);
    else exp_d = flash;
    if (m_cnt != 0) begin
      if (lpm) m_cnt = 0; else m_cnt = m_cnt - 1;
    end else if (we && wd[0] && (wd[3] || wd[5])) begin
      m_cnt = 3;
      m_sig = wd[5];
    end
    exp_ctl = (m_cnt != 0) ? (m_sig ? 8'h21 : 8'h09) : 8'h00;
    @(posedge clk_i); #2;
    check(rd_valid_o == lpm, "R11 valid", rd_valid_o, lpm);
    if (lpm) check(rd_data_o == exp_d, req, rd_data_o, exp_d);
    check(busy_o == (m_cnt != 0), "R2 busy", busy_o, m_cnt != 0);
    check(ctl_rdata_o == exp_ctl, "R1 ctl", ctl_rdata_o, exp_ctl);
    @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 16'h0, "");
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C1A));
    randomize_static();
    repeat (3) @(negedge clk_i);
    // R12 reset state
    check(busy_o == 0 && rd_valid_o == 0, "R12 flags", {busy_o, rd_valid_o}, 0);
    check(rd_data_o == 0 && ctl_rdata_o == 0, "R12 data", {rd_data_o, ctl_rdata_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9 pass-through with no window
    step(0, 8'h00, 1, 16'h0003, "R9 idle flash");
    // R4 R5 fuse map, one window each
    for (int a = 0; a < 5; a++) begin
      step(1, 8'h09, 0, 16'h0, "");
      step(0, 8'h00, 1, 16'(a), a < 4 ? "R4 R5 fuse byte" : "R7 fuse reserved");
      step(0, 8'h00, 1, 16'(a), "R3 back to flash");
    end
    // R6 R7 signature map
    for (int a = 0; a < 9; a++) begin
      step(1, 8'h21, 0, 16'h0, "");
      step(0, 8'h00, 1, 16'(a), "R6 R7 sig byte");
    end
    step(1, 8'h21, 0, 16'h0, "");
    step(0, 8'h00, 1, 16'h8001, "R7 sig wide reserved");
    // R2 last cycle of window still redirects
    step(1, 8'h09, 0, 16'h0, "");
    idle(2);
    step(0, 8'h00, 1, 16'h0001, "R2 third cycle redirect");
    // R2 expired window reads flash
    step(1, 8'h21, 0, 16'h0, "");
    idle(3);
    step(0, 8'h00, 1, 16'h0000, "R2 expired flash");
    // R8 both mode bits
    step(1, 8'h29, 0, 16'h0, "");
    step(0, 8'h00, 1, 16'h0004, "R8 sig priority");
    // R1 enable or mode missing
    step(1, 8'h28, 0, 16'h0, "");
    step(1, 8'h01, 1, 16'h0000, "R1 no arm flash");
    // R10 write while busy ignored
    step(1, 8'h09, 0, 16'h0, "");
    step(1, 8'h21, 0, 16'h0, "");
    step(1, 8'h21, 0, 16'h0, "");
    step(0, 8'h00, 1, 16'h0002, "R10 fuse kept");
    // arm in same cycle as idle LPM
    step(1, 8'h21, 1, 16'h0002, "R9 flash on arm cycle");
    step(0, 8'h00, 1, 16'h0002, "R3 sig after arm");

    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      if (i % 500 == 0) randomize_static();
      a = ($urandom % 8 == 0) ? 16'($urandom) : 16'($urandom % 10);
      step(($urandom % 4) == 0, 8'($urandom), ($urandom % 3) == 0, a, "R3 random read");
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule